// File: doc/BRIEF.md
# Tick-Driven Watchdog Reset Timer

This block is a small watchdog for a low-power controller. It counts slow ticks with a 2-bit state counter. If software does not service it, it asks for a system reset. Two single-cycle enable pulses, synchronous to the system clock, pace it:

- a one-second tick, which advances the counter;
- a half-second tick, which times the reset request once the counter has reached its terminal state.

Software sees one 4-bit control word. The top bit is a write-one service strobe that clears the counter. The next bit is a stored sleep-enable flag that this block only holds. The two low bits are the current counter value and are read only.

The reset request is a one-cycle pulse that drives the system reset. The block treats its own request as a synchronous clear: on the following cycle the counter and the sleep flag return to their reset values, so the watchdog is running again straight after the reset it caused. An inhibit input holds the counter at zero and suppresses the request. The watchdog has no separate standby input, so it keeps counting whenever ticks arrive.

Top module: `wdt_tick_timer`

## Requirements
- R1: After reset the counter reads 00, the sleep flag reads 0 and the reset request is low.
- R2: Each slow tick advances the counter 00, 01, 10, 11 in that order. Once at 11 it holds at 11.
- R3: A write with bit 3 set clears the counter to 00 in the next cycle, and counting resumes immediately. A write with bit 3 clear leaves the counter unchanged. When a service write and a slow tick arrive in the same cycle, the service write wins.
- R4: Read bit 3 is always 0.
- R5: Read bit 2 is the sleep-enable flag. Every write stores write-data bit 2 there. Read bits 1:0 are the counter, with bit 1 as MSB. Writes to bits 1:0 have no effect.
- R6: While the counter reads 11, a fast tick raises the reset request in the next cycle, unless a service write or inhibit occurs in the same cycle. Therefore, with no service, the request appears at the first fast tick after the third slow tick.
- R7: The reset request lasts exactly one cycle. In the cycle after it, the counter reads 00 and the sleep flag reads 0.
- R8: While inhibit is high, the counter reads 00 and the reset request never asserts.
- R9: Regular service writes, at least once per two slow ticks, keep the reset request low indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_slow_i | input | 1 | One-second tick, single-cycle pulse |
| tick_fast_i | input | 1 | Half-second tick, single-cycle pulse |
| inhibit_i | input | 1 | Disables the watchdog while high |
| reg_wr_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 4 | Write data: bit 3 service, bit 2 sleep flag |
| reg_rdata_o | output | 4 | Read data: 0, sleep flag, counter[1:0] |
| rst_req_o | output | 1 | System reset request pulse |

## Verification
The assertions check these rules on every cycle:
- the counter steps by one on a slow tick;
- a service write or inhibit clears the counter;
- the terminal state plus a fast tick raises the request;
- the request is a single cycle followed by a cleared state;
- the sleep flag follows writes;
- a request never appears unless the counter was at 11.

Only the bench scenarios can show behaviour over long periods. That includes the exact tick count before an unserviced reset, the absence of any request under regular service, and the absence of any request across long stretches of inhibit. The bench also sweeps every counter state against every combination of tick, write and inhibit inputs, using a model built from the requirements.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned SVC_BIT = 3;
  localparam int unsigned SLP_BIT = 2;
endpackage

// File: rtl/wdt_state_cnt.sv
module wdt_state_cnt #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             term_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (tick_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign term_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg #(
  parameter int unsigned CNT_W = 2,
  localparam int unsigned REG_W = CNT_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sys_clr_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             svc_o,
  output logic [REG_W-1:0] rdata_o
);
  import wdt_pkg::*;

  logic sleep_q;
  logic unused_wdata;

  // Low write bits map onto the read-only counter.
  assign unused_wdata = ^wdata_i[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sleep_q <= 1'b0;
    else if (sys_clr_i) sleep_q <= 1'b0;
    else if (wr_i)      sleep_q <= wdata_i[CNT_W];
  end

  assign svc_o   = wr_i & wdata_i[REG_W-1];
  assign rdata_o = {1'b0, sleep_q, cnt_i};
endmodule

// File: rtl/wdt_fire.sv
module wdt_fire (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic term_i,
  input  logic tick_fast_i,
  input  logic block_i,
  output logic req_o
);
  logic req_q;

  // The request clears itself, because it acts as the system reset.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    req_q <= 1'b0;
    else if (req_q) req_q <= 1'b0;
    else            req_q <= term_i & tick_fast_i & ~block_i;
  end

  assign req_o = req_q;
endmodule

// File: rtl/wdt_tick_timer.sv
module wdt_tick_timer #(
  parameter int unsigned CNT_W = 2,
  localparam int unsigned REG_W = CNT_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_slow_i,
  input  logic             tick_fast_i,
  input  logic             inhibit_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] cnt;
  logic             term;
  logic             svc;
  logic             req;
  logic             cnt_clr;

  assign cnt_clr = svc | inhibit_i | req;

  wdt_state_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .tick_i (tick_slow_i),
    .cnt_o  (cnt),
    .term_o (term)
  );

  wdt_ctrl_reg #(.CNT_W(CNT_W)) i_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sys_clr_i (req),
    .wr_i      (reg_wr_i),
    .wdata_i   (reg_wdata_i),
    .cnt_i     (cnt),
    .svc_o     (svc),
    .rdata_o   (reg_rdata_o)
  );

  wdt_fire i_fire (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .term_i      (term),
    .tick_fast_i (tick_fast_i),
    .block_i     (svc | inhibit_i),
    .req_o       (req)
  );

  assign rst_req_o = req;
endmodule

// File: rtl/wdt_tick_timer_chk.sv
module wdt_tick_timer_chk #(
  parameter int unsigned CNT_W = 2,
  localparam int unsigned REG_W = CNT_W + 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_slow_i,
  input logic             tick_fast_i,
  input logic             inhibit_i,
  input logic             reg_wr_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic             rst_req_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic             svc;
  assign cnt = reg_rdata_o[CNT_W-1:0];
  assign svc = reg_wr_i & reg_wdata_i[REG_W-1];

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_slow_i && !svc && !inhibit_i && !rst_req_o && cnt != CNT_MAX
    |=> cnt == $past(cnt) + 1'b1);

  a_r3_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc |=> cnt == '0);

  a_r5_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && !rst_req_o |=> reg_rdata_o[CNT_W] == $past(reg_wdata_i[CNT_W]));

  a_r6_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt == CNT_MAX && tick_fast_i && !svc && !inhibit_i && !rst_req_o
    |=> rst_req_o);

  a_r6_only_terminal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(cnt) == CNT_MAX);

  a_r7_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o && cnt == '0 && !reg_rdata_o[CNT_W]);

  a_r8_inhibit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |=> cnt == '0 && !rst_req_o);
endmodule

bind wdt_tick_timer wdt_tick_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_slow_i (tick_slow_i),
  .tick_fast_i (tick_fast_i),
  .inhibit_i   (inhibit_i),
  .reg_wr_i    (reg_wr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .rst_req_o   (rst_req_o)
);

// File: tb/test_wdt_tick_timer.sv
module test_wdt_tick_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ts = 1'b0, tf = 1'b0, inh = 1'b0, wr = 1'b0;
  logic [3:0] wd = 4'h0;
  logic [3:0] rd;
  logic       req;
  int checks = 0, fails = 0;
  logic [1:0] m_cnt;
  logic       m_slp, m_req;

  always #2.5 clk = ~clk;

  wdt_tick_timer i_wdt_tick_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_slow_i(ts), .tick_fast_i(tf),
    .inhibit_i(inh), .reg_wr_i(wr), .reg_wdata_i(wd),
    .reg_rdata_o(rd), .rst_req_o(req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive on the falling edge, sample just after the rising edge.
  // The model follows R2-R8.
  task automatic step(input logic s, input logic f, input logic w,
                      input logic [3:0] d, input logic i);
    logic sv;
    @(negedge clk);
    ts = s; tf = f; wr = w; wd = d; inh = i;
    sv = w & d[3];
    if (m_req) begin
      m_req = 0; m_cnt = 0; m_slp = 0;
    end else begin
      m_req = !i && !sv && f && m_cnt == 2'd3;
      if (w) m_slp = d[2];
      if (i || sv) m_cnt = 0;
      else if (s && m_cnt != 2'd3) m_cnt = m_cnt + 1;
    end
    @(posedge clk); #1;
    chk("R2/R3/R8 counter", int'(rd[1:0]), int'(m_cnt));
    chk("R4 bit3", int'(rd[3]), 0);
    chk("R5 sleep", int'(rd[2]), int'(m_slp));
    chk("R6/R7 rst_req", int'(req), int'(m_req));
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog timeout");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int slow_n, fast_after, fired;
    m_cnt = 0; m_slp = 0; m_req = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 rdata", int'(rd), 0);
    chk("R1 rst_req", int'(req), 0);
    @(negedge clk); rst_n = 1'b1;

    // R6: no service, count ticks until the request
    slow_n = 0; fast_after = 0; fired = 0;
    for (int k = 0; k < 200 && !fired; k++) begin
      step(k % 16 == 15, k % 8 == 7, 0, 4'h0, 0);
      if (k % 16 == 15) slow_n++;
      else if (k % 8 == 7 && slow_n >= 3) fast_after++;
      if (req) fired = 1;
    end
    chk("R6 fired", fired, 1);
    chk("R6 slow ticks before fire", slow_n, 3);
    chk("R6 fast ticks after third slow", fast_after, 1);
    step(0, 0, 0, 4'h0, 0);
    chk("R7 cleared after pulse", int'({req, rd}), 0);

    // R9: service every second slow tick
    fired = 0;
    for (int k = 0; k < 2000; k++) begin
      step(k % 16 == 15, k % 8 == 7, k % 32 == 20, 4'h8, 0);
      if (req) fired = 1;
    end
    chk("R9 no reset under service", fired, 0);

    // R8: inhibit over many ticks
    fired = 0;
    for (int k = 0; k < 2000; k++) begin
      step(k % 16 == 15, k % 8 == 7, 0, 4'h0, 1);
      if (req || rd[1:0] != 0) fired = 1;
    end
    chk("R8 inhibit holds", fired, 0);

    // R3/R5: all write data values
    for (int v = 0; v < 16; v++) begin
      step(1, 0, 0, 4'h0, 0);
      step(0, 0, 1, 4'(v), 0);
    end

    // Sweep: every counter state against every input combination
    for (int c = 0; c < 4; c++) begin
      for (int combo = 0; combo < 64; combo++) begin
        step(0, 0, 1, 4'h8, 0);
        step(0, 0, 0, 4'h0, 0);
        for (int t = 0; t < c; t++) step(1, 0, 0, 4'h0, 0);
        step(combo[0], combo[1], combo[2], {combo[3], combo[5], 2'b11}, combo[4]);
        step(0, 0, 0, 4'h0, 0);
      end
    end

    // R3: service and slow tick in the same cycle
    step(1, 0, 1, 4'h8, 0);
    chk("R3 service beats tick", int'(rd[1:0]), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule